// File: doc/BRIEF.md
# Programmable Wait-State SRAM Cycle Controller

This block turns single read or write requests into bus cycles for an asynchronous static RAM. All of its outputs are timed to the bus clock. A request carries an address, write data, a direction flag and an area number. The area number picks one chip select and one set of timing values: an optional setup clock, from zero to fifteen access-wait clocks, and from zero to three hold clocks. The controller drives the address, the one-hot chip selects, the direction line, the read and write strobes, a one-clock bus-start marker and the write data. For a read, it captures the returned data and reports completion with a one-clock done pulse.

Two designated areas may keep the read strobe active through the hold clocks, which gives slow parts a later negate point. An area set to byte-control mode always uses the early negate point, whatever its delay bit says. The controller takes a new request only while it is idle. A request offered during a cycle is not remembered.

Top module: `sram_wait_ctrl`

## Requirements
- R1: Each cycle runs its states in a fixed order: optional setup, T1, access waits, T2, optional holds. The chip select of the addressed area is low for setup + wait + hold + 2 clocks. Chip select bit n goes with area n.
- R2: Each area's setup bit adds either zero clocks or one clock before T1.
- R3: Each area's 4-bit wait field (0 to 15) puts that many clocks between T1 and T2. For a write, this makes the write strobe low for wait + 2 clocks.
- R4: Each area's 2-bit hold field (0 to 3) adds that many clocks after T2. The chip select stays low during them.
- R5: The read strobe goes low at T1 and goes high again after T2. When the late-negate bit of a designated area is 1, it goes high after the last hold clock instead. Bit 0 of the late-negate input belongs to area 1 and bit 1 to area 4. No other area can use the late point.
- R6: An area set to byte-control mode uses the early negate point even when its late-negate bit is 1.
- R7: The bus-start line (active low) is low for exactly one clock in each cycle, and that clock is T1.
- R8: Chip select, address and the direction line (1 = read, 0 = write) stay constant for the whole cycle. The write strobe is low only from T1 to T2, and only for writes. During a write, the data bus is driven with the request data.
- R9: Read data is captured on the clock edge that ends T2. The done pulse lasts one clock, in the first clock after the last bus state. Requests are taken only while ready is high (idle), and a request offered while busy has no effect.
- R10: While reset is held, every chip select and strobe is high, done is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | NUM_AREAS | Setup-clock enable, one bit per area |
| cfg_wait | input | NUM_AREAS*4 | Access-wait count, 4 bits per area |
| cfg_hold | input | NUM_AREAS*2 | Hold count, 2 bits per area |
| cfg_byte_ctl | input | NUM_AREAS | Byte-control mode, one bit per area |
| cfg_rd_late | input | 2 | Late read-negate bits for area 1 (bit 0) and area 4 (bit 1) |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | 3 | Area number |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Idle, so a request can be taken |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 64 | Captured read data |
| bus_addr | output | 26 | Address to the memory |
| bus_cs_n | output | NUM_AREAS | Chip selects, active low |
| bus_rdwr | output | 1 | Direction, 1 = read |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_bs_n | output | 1 | Bus-start marker, active low |
| bus_dout | output | 64 | Write data to the memory |
| bus_dout_en | output | 1 | Data bus drive enable |
| bus_din | input | 64 | Read data from the memory |

## Verification
The assertions assume that the configuration inputs and the request fields do not change in a way that matters while a cycle is running. They also assume that reset is the only way to cut a cycle short. The stimulus sets up each area's timing before it offers the request, and changes the configuration only between cycles. The only request it offers during a cycle is the one that checks that busy-time requests are ignored. The memory model drives its good read value only during T2, so capturing on any other edge returns a wrong value.

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl #(
  parameter int ADDR_W     = 26,
  parameter int DATA_W     = 64,
  parameter int NUM_AREAS  = 8,
  parameter int WAIT_W     = 4,
  parameter int HOLD_W     = 2,
  parameter int LATE_AREA0 = 1,
  parameter int LATE_AREA1 = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_AREAS-1:0]        cfg_setup,
  input  logic [NUM_AREAS*WAIT_W-1:0] cfg_wait,
  input  logic [NUM_AREAS*HOLD_W-1:0] cfg_hold,
  input  logic [NUM_AREAS-1:0]        cfg_byte_ctl,
  input  logic [1:0]                  cfg_rd_late,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [$clog2(NUM_AREAS)-1:0] req_area,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        req_ready,
  output logic                        rsp_done,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [ADDR_W-1:0]           bus_addr,
  output logic [NUM_AREAS-1:0]        bus_cs_n,
  output logic                        bus_rdwr,
  output logic                        bus_oe_n,
  output logic                        bus_we_n,
  output logic                        bus_bs_n,
  output logic [DATA_W-1:0]           bus_dout,
  output logic                        bus_dout_en,
  input  logic [DATA_W-1:0]           bus_din
);

  localparam int AREA_W = $clog2(NUM_AREAS);
  localparam int CNT_W  = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_T1, S_WAIT, S_T2, S_HOLD
  } state_t;

  state_t              st;
  logic [CNT_W-1:0]    cnt;
  logic [AREA_W-1:0]   area_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q;
  logic [WAIT_W-1:0]   wait_q;
  logic [HOLD_W-1:0]   hold_q;
  logic                late_q;

  logic [WAIT_W-1:0]   sel_wait;
  logic [HOLD_W-1:0]   sel_hold;
  logic                sel_setup;
  logic                sel_late;
  logic                busy;
  logic                strobe_ph;

  assign sel_wait  = cfg_wait[req_area*WAIT_W +: WAIT_W];
  assign sel_hold  = cfg_hold[req_area*HOLD_W +: HOLD_W];
  assign sel_setup = cfg_setup[req_area];
  assign sel_late  = !cfg_byte_ctl[req_area] &&
                     ((req_area == AREA_W'(LATE_AREA0) && cfg_rd_late[0]) ||
                      (req_area == AREA_W'(LATE_AREA1) && cfg_rd_late[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      area_q    <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      wait_q    <= '0;
      hold_q    <= '0;
      late_q    <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          area_q  <= req_area;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          write_q <= req_write;
          wait_q  <= sel_wait;
          hold_q  <= sel_hold;
          late_q  <= sel_late;
          st      <= sel_setup ? S_SETUP : S_T1;
        end
        S_SETUP: st <= S_T1;
        S_T1: begin
          if (wait_q == '0) st <= S_T2;
          else begin
            st  <= S_WAIT;
            cnt <= CNT_W'(wait_q - 1'b1);
          end
        end
        S_WAIT: begin
          if (cnt == '0) st <= S_T2;
          else cnt <= cnt - 1'b1;
        end
        S_T2: begin
          if (!write_q) rsp_rdata <= bus_din;
          if (hold_q == '0) begin
            st       <= S_IDLE;
            rsp_done <= 1'b1;
          end else begin
            st  <= S_HOLD;
            cnt <= CNT_W'(hold_q - 1'b1);
          end
        end
        S_HOLD: begin
          if (cnt == '0) begin
            st       <= S_IDLE;
            rsp_done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign strobe_ph   = (st == S_T1) || (st == S_WAIT) || (st == S_T2);
  assign req_ready   = !busy;
  assign bus_addr    = addr_q;
  assign bus_cs_n    = busy ? ~(NUM_AREAS'(1) << area_q) : '1;
  assign bus_rdwr    = !(busy && write_q);
  assign bus_oe_n    = !(busy && !write_q && (strobe_ph || (late_q && st == S_HOLD)));
  assign bus_we_n    = !(busy && write_q && strobe_ph);
  assign bus_bs_n    = (st != S_T1);
  assign bus_dout    = wdata_q;
  assign bus_dout_en = busy && write_q;

  p_bs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bs_n |=> bus_bs_n);
  p_bs_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_bs_n |-> (bus_cs_n != '1));
  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  p_we_write_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> (!bus_rdwr && bus_dout_en && bus_oe_n));
  p_oe_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_rdwr && (bus_cs_n != '1)));
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n != '1) |=> ((bus_cs_n == '1) || ($stable(bus_addr) && $stable(bus_cs_n))));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && bus_cs_n == '1));
  p_cs_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_cs_n != '1) && !rsp_done) |=> ((bus_cs_n != '1) || rsp_done));

endmodule

// File: tb/test_sram_wait_ctrl.sv
module test_sram_wait_ctrl;
  localparam int NA = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0]   cfg_setup = '0;
  logic [NA*4-1:0] cfg_wait = '0;
  logic [NA*2-1:0] cfg_hold = '0;
  logic [NA-1:0]   cfg_byte_ctl = '0;
  logic [1:0]      cfg_rd_late = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [2:0]    req_area = '0;
  logic [25:0]   req_addr = '0;
  logic [63:0]   req_wdata = '0;
  logic          req_ready, rsp_done;
  logic [63:0]   rsp_rdata;
  logic [25:0]   bus_addr;
  logic [NA-1:0] bus_cs_n;
  logic          bus_rdwr, bus_oe_n, bus_we_n, bus_bs_n, bus_dout_en;
  logic [63:0]   bus_dout;
  logic [63:0]   bus_din = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sram_wait_ctrl i_sram_wait_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
    .cfg_byte_ctl(cfg_byte_ctl), .cfg_rd_late(cfg_rd_late),
    .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_rdwr(bus_rdwr), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_bs_n(bus_bs_n), .bus_dout(bus_dout),
    .bus_dout_en(bus_dout_en), .bus_din(bus_din)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // entry: [12:10] area, [9] write, [8] setup, [7:4] wait, [3:2] hold, [1] late, [0] byte-ctl
  localparam logic [12:0] VEC [0:9] = '{
    {3'd1, 1'b0, 1'b1, 4'd4,  2'd2, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 4'd4,  2'd2, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b0, 4'd0,  2'd0, 1'b1, 1'b0},
    {3'd4, 1'b0, 1'b0, 4'd15, 2'd3, 1'b1, 1'b0},
    {3'd4, 1'b0, 1'b1, 4'd3,  2'd3, 1'b1, 1'b1},
    {3'd2, 1'b0, 1'b1, 4'd2,  2'd3, 1'b1, 1'b0},
    {3'd0, 1'b1, 1'b1, 4'd4,  2'd2, 1'b0, 1'b0},
    {3'd7, 1'b1, 1'b0, 4'd0,  2'd0, 1'b0, 1'b0},
    {3'd3, 1'b1, 1'b0, 4'd15, 2'd3, 1'b1, 1'b0},
    {3'd5, 1'b0, 1'b0, 4'd7,  2'd1, 1'b0, 1'b0}
  };

  localparam logic [63:0] BAD = 64'hDEAD_BEEF_DEAD_BEEF;

  task automatic run_cycle(input int idx, input logic [12:0] v);
    logic [2:0] area; logic wr, s, late, bc;
    logic [3:0] w; logic [1:0] h;
    logic [25:0] addr; logic [63:0] wdata, good;
    int k, cs_n, oe_n, we_n, bs_n, bs_at, oe_at, exp_oe, exp_we;
    bit addr_bad, cs_bad, rdwr_bad, dout_bad, early_done, late_eff;
    {area, wr, s, w, h, late, bc} = v;
    addr  = 26'(32'h0ABC_DE0 + idx * 32'h1111);
    wdata = {32'hC0DE_0000 + 32'(idx), 32'h5A5A_0000 + 32'(idx)};
    good  = {32'hFACE_0000 + 32'(idx), 32'h1357_0000 + 32'(idx)};
    late_eff = late && !bc && (area == 3'd1 || area == 3'd4);
    k = 0; cs_n = 0; oe_n = 0; we_n = 0; bs_n = 0; bs_at = -1; oe_at = -1;
    addr_bad = 0; cs_bad = 0; rdwr_bad = 0; dout_bad = 0; early_done = 0;
    @(negedge clk);
    cfg_setup = {NA{s}}; cfg_wait = {NA{w}}; cfg_hold = {NA{h}};
    cfg_byte_ctl = {NA{bc}}; cfg_rd_late = {late, late};
    req_area = area; req_write = wr; req_addr = addr; req_wdata = wdata;
    bus_din = BAD; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 64; g++) begin
      if (bus_cs_n == '1) break;
      cs_n++;
      if (bus_cs_n != ~(8'd1 << area)) cs_bad = 1;
      if (bus_addr != addr) addr_bad = 1;
      if (bus_rdwr != !wr) rdwr_bad = 1;
      if (wr && (!bus_dout_en || bus_dout != wdata)) dout_bad = 1;
      if (!bus_bs_n) begin bs_n++; bs_at = k; end
      if (!bus_oe_n) begin oe_n++; if (oe_at < 0) oe_at = k; end
      if (!bus_we_n) we_n++;
      if (rsp_done) early_done = 1;
      bus_din = (k == int'(s) + int'(w) + 1) ? good : BAD;
      k++;
      @(negedge clk);
    end
    exp_we = wr ? int'(w) + 2 : 0;
    exp_oe = wr ? 0 : int'(w) + 2 + (late_eff ? int'(h) : 0);
    chk(cs_n == int'(s) + int'(w) + int'(h) + 2, "R1", "cycle length", 64'(cs_n),
        64'(int'(s) + int'(w) + int'(h) + 2));
    chk(!cs_bad, "R1", "area chip select", 64'(cs_bad), 64'd0);
    chk(bs_n == 1 && bs_at == int'(s), "R7", "bus-start position", 64'(bs_at), 64'(s));
    chk(bs_n == 1, "R2", "setup offset of T1", 64'(bs_n), 64'd1);
    chk(!addr_bad && !rdwr_bad, "R8", "address/direction stable", 64'(addr_bad), 64'd0);
    chk(rsp_done && !early_done && req_ready, "R9", "done after last state",
        64'(rsp_done), 64'd1);
    if (wr) begin
      chk(we_n == exp_we, "R3", "write strobe width", 64'(we_n), 64'(exp_we));
      chk(oe_n == 0 && !dout_bad, "R8", "write drive/no read strobe", 64'(oe_n), 64'd0);
    end else begin
      chk(oe_n == exp_oe, late_eff ? "R5" : (bc ? "R6" : "R4"), "read strobe width",
          64'(oe_n), 64'(exp_oe));
      chk(oe_at == int'(s), "R5", "read strobe start", 64'(oe_at), 64'(s));
      chk(we_n == 0, "R8", "no write strobe on read", 64'(we_n), 64'd0);
      chk(rsp_rdata == good, "R9", "read data sampled at T2", rsp_rdata, good);
    end
    @(negedge clk);
    chk(!rsp_done, "R9", "done single clock", 64'(rsp_done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cs_n;
    bit addr_bad;
    repeat (3) @(negedge clk);
    chk(req_ready && bus_cs_n == '1 && bus_oe_n && bus_we_n && bus_bs_n &&
        !rsp_done && !bus_dout_en && bus_rdwr, "R10", "reset outputs",
        {bus_cs_n, 3'b0, req_ready, bus_oe_n, bus_we_n, bus_bs_n, rsp_done},
        {8'hFF, 3'b0, 5'b11110});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) run_cycle(i, VEC[i]);

    // R9: request offered while busy is ignored
    @(negedge clk);
    cfg_setup = '0; cfg_wait = {NA{4'd6}}; cfg_hold = '0; cfg_byte_ctl = '0;
    req_area = 3'd0; req_write = 1'b0; req_addr = 26'h0111; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cs_n = 0; addr_bad = 0;
    for (int g = 0; g < 40; g++) begin
      if (bus_cs_n == '1) break;
      if (bus_addr != 26'h0111) addr_bad = 1;
      if (cs_n == 2) begin
        req_valid = 1'b1; req_addr = 26'h2222; req_write = 1'b1; req_area = 3'd6;
      end else req_valid = 1'b0;
      cs_n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(cs_n == 8 && !addr_bad, "R9", "busy request ignored", 64'(cs_n), 64'd8);
    cs_n = 0;
    repeat (5) begin @(negedge clk); if (bus_cs_n != '1) cs_n++; end
    chk(cs_n == 0, "R9", "no cycle from busy request", 64'(cs_n), 64'd0);

    // R10: reset during a cycle returns the bus to idle
    req_write = 1'b1; req_area = 3'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(bus_cs_n == '1 && bus_we_n && bus_oe_n && req_ready && !rsp_done, "R10",
        "reset mid-cycle", 64'(bus_cs_n), 64'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule